// File: doc/BRIEF.md
# Linear CCD Line Clock Sequencer

This block produces the digital drive pattern for one line of a dual-output linear image sensor. It works in cycles of one fast system clock. Each line request runs two phases. The transfer phase brackets a transfer-gate pulse with guard intervals. The readout phase runs two complementary register clocks and pulses the reset clock once per shifted element. A per-element strobe marks each element as prescan, useful or postscan. The two video outputs are synchronous, so one set of strobes tags both of them. An optional electronic shutter pulses the antiblooming gate at a programmed point in the line to shorten the exposure.

The pixel half-period, the transfer width, the guard width, the postscan count, and the shutter offset and width are runtime values in system-clock cycles. The block captures them when it accepts a request and raises any value that is below its minimum to that minimum. Software, or an upper controller, raises `start` and waits for `busy` to drop. The sampling logic qualifies video on `pixel_valid`.

Top module: `ccd_line_sequencer`

## Requirements
- R1: While idle (`busy`=0), and in reset, the outputs are: `xfer_gate`=0, `reg_clk1`=1, `reg_clk2`=0, `rst_clk`=0, `ab_gate`=0, `pixel_valid`=0, all class flags 0, and `pixel_index`=0.
- R2: `start` is accepted only on a clock edge where `busy`=0. The next cycle is line cycle 0: `busy` rises and `line_start` is high for that cycle only. A `start` seen while `busy`=1 has no effect.
- R3: The line begins with G cycles of `xfer_gate`=0, then W cycles of `xfer_gate`=1, then G more cycles of `xfer_gate`=0. Throughout this period `reg_clk1`=1 and `reg_clk2`=0. Values are clamped so that W ≥ XFER_MIN (16) and G ≥ GUARD_MIN (1).
- R4: Readout follows the transfer phase as N consecutive elements of 2H cycles each. During the first H cycles of an element `reg_clk2`=1 and `reg_clk1`=0. During the last H cycles the levels swap. H is clamped so that H ≥ HALF_MIN (1).
- R5: During readout `rst_clk` is high only in the first cycle of each element. During the transfer period `rst_clk` equals the captured hold flag.
- R6: `pixel_valid` is high for exactly one cycle per element, the cycle in which `reg_clk2` falls. In that cycle `pixel_index` gives the element number counted from 0, so the first useful element (index 4) comes with the 5th falling edge.
- R7: N = 4 + 1024 + P, where P is the postscan count. With `pixel_valid` high, exactly one flag is set: `is_prescan` for indices 0–3, `is_useful` for 4–1027, and `is_postscan` for higher indices. With `pixel_valid` low, no flag is set.
- R8: When the shutter is enabled with offset S, `ab_gate` is high for cycles S+1 to S+Ws of the line. Ws is clamped so that Ws ≥ SHUT_MIN (10).
- R9: A shutter offset S at or beyond the line length L = 2G + W + 2HN produces no pulse. A pulse that runs past L keeps `busy` high until the pulse ends.
- R10: All runtime settings are captured at acceptance. Changes to them while `busy`=1 do not affect the current line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Line request |
| cfg_half | input | 8 | Register-clock half period, cycles |
| cfg_xfer | input | 8 | Transfer pulse width, cycles |
| cfg_guard | input | 8 | Guard width each side of the transfer pulse, cycles |
| cfg_post | input | 8 | Postscan element count |
| cfg_shut_en | input | 1 | Shutter enable |
| cfg_shut_at | input | 20 | Shutter offset in line cycles |
| cfg_shut_len | input | 8 | Shutter pulse width, cycles |
| cfg_rst_hold | input | 1 | Hold reset clock high during transfer |
| busy | output | 1 | Line or shutter pulse in progress |
| line_start | output | 1 | First cycle of a line |
| xfer_gate | output | 1 | Transfer-gate drive |
| reg_clk1 | output | 1 | Register clock 1 drive |
| reg_clk2 | output | 1 | Register clock 2 drive |
| rst_clk | output | 1 | Reset clock drive |
| ab_gate | output | 1 | Antiblooming gate drive |
| pixel_valid | output | 1 | Element strobe |
| is_prescan | output | 1 | Element is prescan |
| is_useful | output | 1 | Element is useful |
| is_postscan | output | 1 | Element is postscan |
| pixel_index | output | 11 | Element number within the line |

## Verification
A phase counter that ends one cycle early or late shifts every later clock edge. That error shows on `xfer_gate` or `reg_clk1` in the cycle where the phase should have changed. An error in the element counter appears on the first strobe after it, as a wrong `pixel_index` or a wrong class flag. A wrong end count shows at the line's tail as an extra or missing element and a `busy` that drops at the wrong cycle. A stuck shutter state shows in `ab_gate` and `busy` within one shutter width. Because the bench compares every output in every cycle, each such fault is reported in the cycle where it first appears.

// File: rtl/ccdseq_pkg.sv
package ccdseq_pkg;

    localparam int CFG_W  = 8;
    localparam int LINE_W = 20;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_GPRE,
        PH_XFER,
        PH_GPOST,
        PH_READ
    } phase_e;

    typedef enum logic [1:0] {
        PX_NONE,
        PX_PRE,
        PX_USE,
        PX_POST
    } pixclass_e;

    typedef struct packed {
        logic [CFG_W-1:0]  half;
        logic [CFG_W-1:0]  xfer;
        logic [CFG_W-1:0]  guard;
        logic [CFG_W-1:0]  post;
        logic              shut_en;
        logic [LINE_W-1:0] shut_at;
        logic [CFG_W-1:0]  shut_len;
        logic              rst_hold;
    } line_cfg_t;

    function automatic logic [CFG_W-1:0] floor_to(input logic [CFG_W-1:0] v,
                                                  input int unsigned      m);
        return (v < CFG_W'(m)) ? CFG_W'(m) : v;
    endfunction

endpackage

// File: rtl/ccdseq_frame_ctrl.sv
module ccdseq_frame_ctrl
    import ccdseq_pkg::*;
#(
    parameter int CW = CFG_W,
    parameter int LW = LINE_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          accept,
    input  logic [CW-1:0] guard_len,
    input  logic [CW-1:0] xfer_len,
    input  logic          read_done,
    output phase_e        phase,
    output logic [LW-1:0] line_time,
    output logic          line_start
);
    phase_e        ph_q;
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] guard_last;
    logic [CW-1:0] xfer_last;

    assign guard_last = CW'(guard_len - 1'b1);
    assign xfer_last  = CW'(xfer_len - 1'b1);

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q      <= PH_IDLE;
            cnt_q     <= '0;
            line_time <= '0;
        end else begin
            if (ph_q != PH_IDLE && line_time != '1)
                line_time <= line_time + 1'b1;
            case (ph_q)
                PH_IDLE: begin
                    if (accept) begin
                        ph_q      <= PH_GPRE;
                        cnt_q     <= '0;
                        line_time <= '0;
                    end
                end
                PH_GPRE: begin
                    if (cnt_q == guard_last) begin
                        ph_q  <= PH_XFER;
                        cnt_q <= '0;
                    end else cnt_q <= cnt_q + 1'b1;
                end
                PH_XFER: begin
                    if (cnt_q == xfer_last) begin
                        ph_q  <= PH_GPOST;
                        cnt_q <= '0;
                    end else cnt_q <= cnt_q + 1'b1;
                end
                PH_GPOST: begin
                    if (cnt_q == guard_last) begin
                        ph_q  <= PH_READ;
                        cnt_q <= '0;
                    end else cnt_q <= cnt_q + 1'b1;
                end
                PH_READ: begin
                    if (read_done) ph_q <= PH_IDLE;
                end
                default: ph_q <= PH_IDLE;
            endcase
        end
    end

    assign phase      = ph_q;
    assign line_start = (ph_q == PH_GPRE) && (line_time == '0);
endmodule

// File: rtl/ccdseq_readout.sv
module ccdseq_readout
    import ccdseq_pkg::*;
#(
    parameter int PRESCAN = 4,
    parameter int USEFUL  = 1024,
    parameter int IW      = 11,
    parameter int CW      = CFG_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          active,
    input  logic [CW-1:0] half_len,
    input  logic [IW-1:0] elem_count,
    output logic          reg1,
    output logic          reg2,
    output logic          rst_pulse,
    output logic          pix_valid,
    output pixclass_e     pix_class,
    output logic [IW-1:0] pix_idx,
    output logic          last_cycle
);
    logic [CW-1:0] half_q;
    logic          second_q;
    logic [IW-1:0] idx_q;
    logic          half_end;
    logic          in_pre;
    logic          in_use;

    assign half_end = (half_q == CW'(half_len - 1'b1));

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            half_q   <= '0;
            second_q <= 1'b0;
            idx_q    <= '0;
        end else if (half_end) begin
            half_q <= '0;
            if (second_q) begin
                second_q <= 1'b0;
                idx_q    <= idx_q + 1'b1;
            end else begin
                second_q <= 1'b1;
            end
        end else begin
            half_q <= half_q + 1'b1;
        end
    end

    generate
        if (PRESCAN == 0) begin : g_no_pre
            assign in_pre = 1'b0;
        end else begin : g_pre
            assign in_pre = (idx_q < IW'(PRESCAN));
        end
    endgenerate

    assign in_use = (idx_q < IW'(PRESCAN + USEFUL));

    assign reg1       = active ? second_q : 1'b1;
    assign reg2       = active && !second_q;
    assign rst_pulse  = active && !second_q && (half_q == '0);
    assign pix_valid  = active && second_q && (half_q == '0);
    assign pix_idx    = pix_valid ? idx_q : '0;
    assign last_cycle = active && second_q && half_end
                        && (idx_q == IW'(elem_count - 1'b1));

    always_comb begin
        if (!pix_valid)  pix_class = PX_NONE;
        else if (in_pre) pix_class = PX_PRE;
        else if (in_use) pix_class = PX_USE;
        else             pix_class = PX_POST;
    end
endmodule

// File: rtl/ccdseq_shutter.sv
module ccdseq_shutter
    import ccdseq_pkg::*;
#(
    parameter int CW = CFG_W,
    parameter int LW = LINE_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          line_active,
    input  logic [LW-1:0] line_time,
    input  logic          enable,
    input  logic [LW-1:0] start_at,
    input  logic [CW-1:0] width,
    output logic          gate
);
    logic          on_q;
    logic [CW-1:0] cnt_q;
    logic          fire;

    assign fire = line_active && enable && (line_time == start_at) && !on_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            on_q  <= 1'b0;
            cnt_q <= '0;
        end else if (fire) begin
            on_q  <= 1'b1;
            cnt_q <= '0;
        end else if (on_q) begin
            if (cnt_q == CW'(width - 1'b1)) on_q <= 1'b0;
            else                            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign gate = on_q;
endmodule

// File: rtl/ccd_line_sequencer.sv
module ccd_line_sequencer
    import ccdseq_pkg::*;
#(
    parameter int PRESCAN   = 4,
    parameter int USEFUL    = 1024,
    parameter int HALF_MIN  = 1,
    parameter int XFER_MIN  = 16,
    parameter int GUARD_MIN = 1,
    parameter int SHUT_MIN  = 10,
    localparam int IDX_W    = $clog2(PRESCAN + USEFUL + (1 << CFG_W))
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [CFG_W-1:0]  cfg_half,
    input  logic [CFG_W-1:0]  cfg_xfer,
    input  logic [CFG_W-1:0]  cfg_guard,
    input  logic [CFG_W-1:0]  cfg_post,
    input  logic              cfg_shut_en,
    input  logic [LINE_W-1:0] cfg_shut_at,
    input  logic [CFG_W-1:0]  cfg_shut_len,
    input  logic              cfg_rst_hold,
    output logic              busy,
    output logic              line_start,
    output logic              xfer_gate,
    output logic              reg_clk1,
    output logic              reg_clk2,
    output logic              rst_clk,
    output logic              ab_gate,
    output logic              pixel_valid,
    output logic              is_prescan,
    output logic              is_useful,
    output logic              is_postscan,
    output logic [IDX_W-1:0]  pixel_index
);
    line_cfg_t         cfg_q;
    phase_e            phase;
    logic [LINE_W-1:0] line_time;
    logic              accept;
    logic              read_done;
    logic              rst_pulse;
    logic              in_xfer_period;
    pixclass_e         pix_class;
    logic [IDX_W-1:0]  elem_count;

    assign accept = start && !busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (accept) begin
            cfg_q.half     <= floor_to(cfg_half, HALF_MIN);
            cfg_q.xfer     <= floor_to(cfg_xfer, XFER_MIN);
            cfg_q.guard    <= floor_to(cfg_guard, GUARD_MIN);
            cfg_q.post     <= cfg_post;
            cfg_q.shut_en  <= cfg_shut_en;
            cfg_q.shut_at  <= cfg_shut_at;
            cfg_q.shut_len <= floor_to(cfg_shut_len, SHUT_MIN);
            cfg_q.rst_hold <= cfg_rst_hold;
        end
    end

    assign elem_count = IDX_W'(PRESCAN + USEFUL) + IDX_W'(cfg_q.post);

    ccdseq_frame_ctrl #(.CW(CFG_W), .LW(LINE_W)) u_frame (
        .clk        (clk),
        .rst        (rst),
        .accept     (accept),
        .guard_len  (cfg_q.guard),
        .xfer_len   (cfg_q.xfer),
        .read_done  (read_done),
        .phase      (phase),
        .line_time  (line_time),
        .line_start (line_start)
    );

    ccdseq_readout #(
        .PRESCAN (PRESCAN),
        .USEFUL  (USEFUL),
        .IW      (IDX_W),
        .CW      (CFG_W)
    ) u_read (
        .clk        (clk),
        .rst        (rst),
        .active     (phase == PH_READ),
        .half_len   (cfg_q.half),
        .elem_count (elem_count),
        .reg1       (reg_clk1),
        .reg2       (reg_clk2),
        .rst_pulse  (rst_pulse),
        .pix_valid  (pixel_valid),
        .pix_class  (pix_class),
        .pix_idx    (pixel_index),
        .last_cycle (read_done)
    );

    ccdseq_shutter #(.CW(CFG_W), .LW(LINE_W)) u_shut (
        .clk         (clk),
        .rst         (rst),
        .line_active (phase != PH_IDLE),
        .line_time   (line_time),
        .enable      (cfg_q.shut_en),
        .start_at    (cfg_q.shut_at),
        .width       (cfg_q.shut_len),
        .gate        (ab_gate)
    );

    assign in_xfer_period = (phase == PH_GPRE) || (phase == PH_XFER) || (phase == PH_GPOST);
    assign xfer_gate      = (phase == PH_XFER);
    assign rst_clk        = rst_pulse || (in_xfer_period && cfg_q.rst_hold);
    assign busy           = (phase != PH_IDLE) || ab_gate;
    assign is_prescan     = (pix_class == PX_PRE);
    assign is_useful      = (pix_class == PX_USE);
    assign is_postscan    = (pix_class == PX_POST);
endmodule

// File: rtl/ccdseq_checker.sv
module ccdseq_checker #(
    parameter int IW = 11
) (
    input logic          clk,
    input logic          rst,
    input logic          busy,
    input logic          line_start,
    input logic          xfer_gate,
    input logic          reg_clk1,
    input logic          reg_clk2,
    input logic          rst_clk,
    input logic          ab_gate,
    input logic          pixel_valid,
    input logic          is_prescan,
    input logic          is_useful,
    input logic          is_postscan,
    input logic [IW-1:0] pixel_index
);
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!xfer_gate && !ab_gate && !pixel_valid && reg_clk1 && !reg_clk2
                   && pixel_index == '0));

    p_start_once_r2: assert property (@(posedge clk) disable iff (rst)
        line_start |-> (busy && !$past(busy)));

    p_xfer_regs_r3: assert property (@(posedge clk) disable iff (rst)
        xfer_gate |-> (reg_clk1 && !reg_clk2 && !pixel_valid));

    p_guard_gap_r3: assert property (@(posedge clk) disable iff (rst)
        $fell(reg_clk1) |-> (!xfer_gate && !$past(xfer_gate)));

    p_antiphase_r4: assert property (@(posedge clk) disable iff (rst)
        reg_clk1 != reg_clk2);

    p_rst_first_half_r5: assert property (@(posedge clk) disable iff (rst)
        pixel_valid |-> !rst_clk);

    p_valid_on_fall_r6: assert property (@(posedge clk) disable iff (rst)
        pixel_valid |-> $fell(reg_clk2));

    p_one_class_r7: assert property (@(posedge clk) disable iff (rst)
        $countones({is_prescan, is_useful, is_postscan}) == (pixel_valid ? 1 : 0));

    p_ab_min_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(ab_gate) |=> ab_gate);

    p_ab_busy_r9: assert property (@(posedge clk) disable iff (rst)
        ab_gate |-> busy);
endmodule

bind ccd_line_sequencer ccdseq_checker #(.IW(IDX_W)) u_chk (.*);

// File: tb/ccd_line_sequencer_bench.sv
module ccd_line_sequencer_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic [7:0]  cfg_half, cfg_xfer, cfg_guard, cfg_post, cfg_shut_len;
    logic        cfg_shut_en, cfg_rst_hold;
    logic [19:0] cfg_shut_at;
    logic        busy, line_start, xfer_gate, reg_clk1, reg_clk2, rst_clk, ab_gate;
    logic        pixel_valid, is_prescan, is_useful, is_postscan;
    logic [10:0] pixel_index;

    int checks = 0;
    int errors = 0;
    int eH, eW, eG, eP, eEn, eS, eSW, eHold;

    always #10 clk = ~clk;

    ccd_line_sequencer u_ccd_line_sequencer (.*);

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    function automatic int atleast(input int v, input int m);
        return (v < m) ? m : v;
    endfunction

    function automatic int line_len();
        return 2 * eG + eW + (4 + 1024 + eP) * 2 * eH;
    endfunction

    function automatic int ab_exp(input int t);
        int len = line_len();
        return (eEn != 0 && eS < len && t >= eS + 1 && t <= eS + eSW) ? 1 : 0;
    endfunction

    task automatic check_idle(input string tag);
        chk({"R1 ", tag}, "busy", int'(busy), 0);
        chk("R1", "xfer_gate", int'(xfer_gate), 0);
        chk("R1", "reg_clk1", int'(reg_clk1), 1);
        chk("R1", "reg_clk2", int'(reg_clk2), 0);
        chk("R1", "rst_clk", int'(rst_clk), 0);
        chk("R1", "ab_gate", int'(ab_gate), 0);
        chk("R1", "pixel_valid", int'(pixel_valid), 0);
        chk("R1", "classes", int'({is_prescan, is_useful, is_postscan}), 0);
        chk("R1", "pixel_index", int'(pixel_index), 0);
    endtask

    task automatic expect_cycle(input int t);
        int len = line_len();
        int n   = 4 + 1024 + eP;
        int x = 0, r1 = 1, r2 = 0, rc = 0, v = 0, idx = 0, cls = 0;
        int ab  = ab_exp(t);
        int bz  = (t < len || ab != 0) ? 1 : 0;
        if (t < len) begin
            if (t < 2 * eG + eW) begin
                x  = (t >= eG && t < eG + eW) ? 1 : 0;
                rc = eHold;
            end else begin
                int r = t - (2 * eG + eW);
                int k = r / (2 * eH);
                int h = r % (2 * eH);
                r2 = (h < eH) ? 1 : 0;
                r1 = 1 - r2;
                rc = (h == 0) ? 1 : 0;
                v  = (h == eH) ? 1 : 0;
                if (v != 0) begin
                    idx = k;
                    cls = (k < 4) ? 4 : (k < 1028) ? 2 : 1;
                end
                if (k >= n) v = 99;
            end
        end
        chk("R2", "line_start", int'(line_start), (t == 0) ? 1 : 0);
        chk("R2/R9", "busy", int'(busy), bz);
        chk("R3", "xfer_gate", int'(xfer_gate), x);
        chk("R4", "reg_clk1", int'(reg_clk1), r1);
        chk("R4", "reg_clk2", int'(reg_clk2), r2);
        chk("R5", "rst_clk", int'(rst_clk), rc);
        chk("R6", "pixel_valid", int'(pixel_valid), v);
        chk("R6", "pixel_index", int'(pixel_index), idx);
        chk("R7", "class {pre,use,post}", int'({is_prescan, is_useful, is_postscan}), cls);
        chk("R8", "ab_gate", int'(ab_gate), ab);
    endtask

    task automatic run_line(input int h, input int w, input int g, input int p,
                            input int en, input int s, input int sw, input int hold,
                            input int poke_t);
        int len, tend;
        @(negedge clk);
        cfg_half = 8'(h); cfg_xfer = 8'(w); cfg_guard = 8'(g); cfg_post = 8'(p);
        cfg_shut_en = en[0]; cfg_shut_at = 20'(s); cfg_shut_len = 8'(sw);
        cfg_rst_hold = hold[0];
        eH = atleast(h, 1); eW = atleast(w, 16); eG = atleast(g, 1); eP = p;
        eEn = en; eS = s; eSW = atleast(sw, 10); eHold = hold;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        len  = line_len();
        tend = len;
        if (ab_exp(eS + 1) != 0 && eS + eSW + 1 > tend) tend = eS + eSW + 1;
        tend = tend + 3;
        for (int t = 0; t < tend; t++) begin
            if (t > 0) @(negedge clk);
            if (t == poke_t) begin
                // R10: scramble settings and R2: request while busy
                start = 1'b1;
                cfg_half = 8'd7; cfg_xfer = 8'd99; cfg_guard = 8'd9; cfg_post = 8'd200;
                cfg_shut_en = ~cfg_shut_en; cfg_shut_at = 20'd3; cfg_shut_len = 8'd77;
                cfg_rst_hold = ~cfg_rst_hold;
            end else if (t == poke_t + 1) begin
                start = 1'b0;
            end
            expect_cycle(t);
        end
        start = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst = 1'b1; start = 1'b0;
        cfg_half = '0; cfg_xfer = '0; cfg_guard = '0; cfg_post = '0;
        cfg_shut_en = 1'b0; cfg_shut_at = '0; cfg_shut_len = '0; cfg_rst_hold = 1'b0;
        repeat (3) @(negedge clk);
        check_idle("in reset");
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        rst = 1'b0;
        @(negedge clk);
        check_idle("after reset");

        // R3/R4/R6/R7: plain line, no shutter, reset clock low in transfer
        run_line(2, 20, 3, 0, 0, 0, 0, 0, 500);
        check_idle("after line A");

        // R3/R4/R8 clamps, R5 hold, R7 postscan, R2/R10 pokes
        run_line(0, 3, 0, 5, 1, 10, 2, 1, 1200);

        // R8: later shutter, three-cycle half period
        run_line(3, 17, 2, 2, 1, 100, 30, 0, 3000);

        // R9: shutter offset beyond the line produces nothing
        eH = 1; eW = 16; eG = 1; eP = 0;
        run_line(1, 16, 1, 0, 1, line_len() + 5, 40, 1, 50);

        // R9: shutter near the end keeps busy high, poke during the tail (R2)
        eH = 1; eW = 16; eG = 1; eP = 0;
        run_line(1, 16, 1, 0, 1, line_len() - 2, 50, 0, line_len() + 4);
        check_idle("after shutter tail");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule